// File: doc/BRIEF.md
# Load-Use Interlock and Halt Controller

This unit sits beside the decode stage of a five-stage in-order pipeline. It looks at the instruction waiting in the fetch/decode register, the instruction in the decode/execute register and the instruction in the memory/writeback register. It has two jobs.

The first is the load-use stall. A load's data is not ready until the end of its memory stage. If the next instruction reads the register that load writes, the unit holds the PC and the fetch/decode register for one cycle. It also asks for a no-op, the word 0x00000020, to enter the decode/execute register in place of the dependent instruction. Stores are treated like any other reader, because there is no load-to-store bypass in the memory stage. A branch squash in the same cycle takes priority over the stall, so the instructions being flushed are not held.

The second job is halting. A HALT seen at fetch or decode may be on a wrong-path after a mispredicted branch, so it is ignored there. The unit stops the machine only when HALT reaches the memory/writeback register, which is after every older store has written memory. From then on the stop is sticky and freezes the PC and all pipeline registers until reset.

Top module: `hazardCtrlUnit`

## Requirements
- R1: After reset, with no-op words (0x00000020) in all three stage inputs and squash low, all five outputs are 0.
- R2: When the decode/execute word is a load (opcode bits 31:26 = 0x23) with a nonzero destination in bits 20:16, and the fetch/decode word is R-type (opcode 0x00) with either source field (bits 25:21 or bits 20:16) equal to that destination, then pcHold, ifidHold and bubbleInsert are all 1 in the same cycle.
- R3: ADDI (opcode 0x08), load (0x23) and BEQZ (0x04) in fetch/decode are checked on bits 25:21 only. A match in bits 20:16 alone does not stall.
- R4: A store (opcode 0x2B) in fetch/decode stalls when either bits 25:21 or its data register in bits 20:16 equals the load destination.
- R5: A load whose destination is register 0 never causes a stall.
- R6: No stall occurs when the decode/execute word is not a load. No stall occurs when the fetch/decode word is HALT (0x3F), whatever its register fields hold.
- R7: When squash is 1 and the unit is not halted, pcHold, ifidHold and bubbleInsert are 0, even if a load-use hazard is present.
- R8: A HALT word in fetch/decode or decode/execute does not raise haltFlag.
- R9: A HALT word in memory/writeback raises haltFlag and pipeFreeze in the same cycle. Both stay at 1 on every later cycle until reset. While they are 1, pcHold and ifidHold are 1 and bubbleInsert is 0.
- R10: Once halted, squash has no effect: pcHold and ifidHold stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ifidInstr | input | 32 | Instruction word in the fetch/decode register |
| idexInstr | input | 32 | Instruction word in the decode/execute register |
| memwbInstr | input | 32 | Instruction word in the memory/writeback register |
| squash | input | 1 | Branch recovery is flushing the front of the pipe this cycle |
| pcHold | output | 1 | Keep the PC unchanged |
| ifidHold | output | 1 | Keep the fetch/decode register unchanged |
| bubbleInsert | output | 1 | Load the no-op word into decode/execute |
| haltFlag | output | 1 | Machine stop, sticky until reset |
| pipeFreeze | output | 1 | Freeze the decode/execute, execute/memory and memory/writeback registers |

## Verification
The bench builds the unit with its default parameters: 32-bit words, 6-bit opcodes and 5-bit register fields at the standard field positions. With these defaults every decoding path can be reached. That covers a match on the first source field and on the second, the per-opcode choice of which fields to compare, the register-0 exclusion, and HALT sitting in each of the three stages. A behavioural model recomputes all five outputs every cycle. It also tracks the sticky stop across squash pulses and across the reset that clears it.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int REG_AW  = 5;
  localparam int OPC_LSB = 26;
  localparam int RS1_LSB = 21;
  localparam int RS2_LSB = 16;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQZ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_HALT  = 6'h3F;

  // decode facts handed from datapath to control
  typedef struct packed {
    logic loadHit;
    logic haltArrive;
  } hazInfo_t;

  // strobes handed from control back to datapath
  typedef struct packed {
    logic stall;
    logic halt;
  } ctrlStrobes_t;
endpackage

// File: rtl/hzdDatapath.sv
module hzdDatapath
  import hzd_pkg::*;
#(
  parameter int WORD_W  = INSTR_W,
  parameter int OP_W    = OPC_W,
  parameter int RA_W    = REG_AW,
  parameter int OP_LSB  = OPC_LSB,
  parameter int SRC0_LSB = RS1_LSB,
  parameter int SRC1_LSB = RS2_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ifidInstr,
  input  logic [WORD_W-1:0] idexInstr,
  input  logic [WORD_W-1:0] memwbInstr,
  input  ctrlStrobes_t      ctrl,
  output hazInfo_t          info,
  output logic              pcHold,
  output logic              ifidHold,
  output logic              bubbleInsert,
  output logic              haltFlag,
  output logic              pipeFreeze
);
  localparam int NUM_SRC = 2;
  localparam int SRC_LSB [NUM_SRC] = '{SRC0_LSB, SRC1_LSB};

  logic [OP_W-1:0] ifidOp, idexOp, memwbOp;
  logic [RA_W-1:0] loadDst;
  logic [NUM_SRC-1:0] useSlot;
  logic [NUM_SRC-1:0] slotHit;
  logic idexIsLoad;

  assign ifidOp  = ifidInstr[OP_LSB +: OP_W];
  assign idexOp  = idexInstr[OP_LSB +: OP_W];
  assign memwbOp = memwbInstr[OP_LSB +: OP_W];
  assign loadDst = idexInstr[SRC1_LSB +: RA_W];
  assign idexIsLoad = (idexOp == OPC_LOAD);

  // which source fields the decode-stage instruction actually reads
  always_comb begin
    useSlot = '0;
    unique case (ifidOp)
      OPC_RTYPE, OPC_STORE:          useSlot = 2'b11;
      OPC_ADDI, OPC_LOAD, OPC_BEQZ:  useSlot = 2'b01;
      default:                       useSlot = 2'b00;
    endcase
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [RA_W-1:0] srcField;
    assign srcField   = ifidInstr[SRC_LSB[s] +: RA_W];
    assign slotHit[s] = useSlot[s] && (srcField == loadDst);
  end

  assign info.loadHit    = idexIsLoad && (loadDst != '0) && (|slotHit);
  assign info.haltArrive = (memwbOp == OPC_HALT);

  assign bubbleInsert = ctrl.stall;
  assign pcHold       = ctrl.stall | ctrl.halt;
  assign ifidHold     = ctrl.stall | ctrl.halt;
  assign haltFlag     = ctrl.halt;
  assign pipeFreeze   = ctrl.halt;

  // R5: a zero-destination load never produces a hazard
  assert_zero_dst_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idexIsLoad && loadDst == '0) |-> !bubbleInsert);
  // R6: a non-load ahead never causes a bubble
  assert_nonload_no_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !idexIsLoad |-> !bubbleInsert);
  // R9: halted state never injects a bubble but holds the front end
  assert_halt_holds_front_R9: assert property (@(posedge clk) disable iff (!rst_n)
    haltFlag |-> (pcHold && ifidHold && !bubbleInsert));
endmodule

// File: rtl/hzdControl.sv
module hzdControl
  import hzd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         squash,
  input  hazInfo_t     info,
  output ctrlStrobes_t ctrl
);
  logic haltSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               haltSeen <= 1'b0;
    else if (info.haltArrive) haltSeen <= 1'b1;
  end

  assign ctrl.halt  = haltSeen | info.haltArrive;
  assign ctrl.stall = info.loadHit & ~squash & ~ctrl.halt;

  // R9: the stop is sticky
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.halt |=> ctrl.halt);
  // R7: squash wins over the interlock
  assert_squash_beats_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !ctrl.stall);
  // R9: HALT arriving in memory/writeback is recorded for later cycles
  assert_halt_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    info.haltArrive |=> haltSeen);
endmodule

// File: rtl/hazardCtrlUnit.sv
module hazardCtrlUnit
  import hzd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ifidInstr,
  input  logic [INSTR_W-1:0] idexInstr,
  input  logic [INSTR_W-1:0] memwbInstr,
  input  logic               squash,
  output logic               pcHold,
  output logic               ifidHold,
  output logic               bubbleInsert,
  output logic               haltFlag,
  output logic               pipeFreeze
);
  hazInfo_t     info;
  ctrlStrobes_t ctrl;

  hzdDatapath u_dp (
    .clk(clk), .rst_n(rst_n),
    .ifidInstr(ifidInstr), .idexInstr(idexInstr), .memwbInstr(memwbInstr),
    .ctrl(ctrl), .info(info),
    .pcHold(pcHold), .ifidHold(ifidHold), .bubbleInsert(bubbleInsert),
    .haltFlag(haltFlag), .pipeFreeze(pipeFreeze)
  );

  hzdControl u_ctl (
    .clk(clk), .rst_n(rst_n), .squash(squash), .info(info), .ctrl(ctrl)
  );
endmodule

// File: tb/tb_hazardCtrlUnit.sv
module tb_hazardCtrlUnit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h0000_0020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ifidInstr = NOP, idexInstr = NOP, memwbInstr = NOP;
  logic squash = 1'b0;
  logic pcHold, ifidHold, bubbleInsert, haltFlag, pipeFreeze;

  int total = 0;
  int bad = 0;
  bit modelHalt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazardCtrlUnit dut (
    .clk(clk), .rst_n(rst_n), .ifidInstr(ifidInstr), .idexInstr(idexInstr),
    .memwbInstr(memwbInstr), .squash(squash), .pcHold(pcHold), .ifidHold(ifidHold),
    .bubbleInsert(bubbleInsert), .haltFlag(haltFlag), .pipeFreeze(pipeFreeze)
  );

  function automatic logic [31:0] mkR(int a, int b, int d);
    return {6'h00, a[4:0], b[4:0], d[4:0], 11'h020};
  endfunction
  function automatic logic [31:0] mkI(logic [5:0] op, int a, int t, int imm);
    return {op, a[4:0], t[4:0], imm[15:0]};
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
    end
  endtask

  // behavioural reference: which registers does the follower read?
  task automatic step(string tag, logic [31:0] fi, logic [31:0] ie, logic [31:0] mw, logic sq);
    logic [5:0] fop;
    logic rdA, rdB, hit, halt, stall;
    @(negedge clk);
    ifidInstr = fi; idexInstr = ie; memwbInstr = mw; squash = sq;
    #1;
    fop = fi[31:26];
    rdA = (fop == 6'h00) || (fop == 6'h2B) || (fop == 6'h08) || (fop == 6'h23) || (fop == 6'h04);
    rdB = (fop == 6'h00) || (fop == 6'h2B);
    hit = (ie[31:26] == 6'h23) && (ie[20:16] != 0) &&
          ((rdA && fi[25:21] == ie[20:16]) || (rdB && fi[20:16] == ie[20:16]));
    halt  = modelHalt || (mw[31:26] == 6'h3F);
    stall = hit && !sq && !halt;
    chk(tag, "pcHold", pcHold, stall || halt);
    chk(tag, "ifidHold", ifidHold, stall || halt);
    chk(tag, "bubbleInsert", bubbleInsert, stall);
    chk(tag, "haltFlag", haltFlag, halt);
    chk(tag, "pipeFreeze", pipeFreeze, halt);
    if (mw[31:26] == 6'h3F) modelHalt = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ld3, hlt;
    ld3 = mkI(6'h23, 1, 3, 8);
    hlt = 32'hFC00_0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step("R1", NOP, NOP, NOP, 0);
    // R2 both R-type source fields
    step("R2", mkR(3, 4, 5), ld3, NOP, 0);
    step("R2", mkR(4, 3, 5), ld3, NOP, 0);
    step("R2", mkR(4, 5, 3), ld3, NOP, 0);
    // R3 single-source forms
    step("R3", mkI(6'h08, 3, 1, 4), ld3, NOP, 0);
    step("R3", mkI(6'h08, 1, 3, 4), ld3, NOP, 0);
    step("R3", mkI(6'h23, 3, 2, 0), ld3, NOP, 0);
    step("R3", mkI(6'h23, 2, 3, 0), ld3, NOP, 0);
    step("R3", mkI(6'h04, 3, 0, 8), ld3, NOP, 0);
    step("R3", mkI(6'h04, 0, 3, 8), ld3, NOP, 0);
    // R4 store reads both
    step("R4", mkI(6'h2B, 3, 1, 0), ld3, NOP, 0);
    step("R4", mkI(6'h2B, 1, 3, 0), ld3, NOP, 0);
    // R5 register zero
    step("R5", mkR(0, 0, 0), mkI(6'h23, 1, 0, 0), NOP, 0);
    // R6 non-load ahead, HALT follower
    step("R6", mkR(3, 3, 1), mkI(6'h08, 1, 3, 1), NOP, 0);
    step("R6", mkR(3, 3, 1), mkI(6'h2B, 1, 3, 0), NOP, 0);
    step("R6", hlt | (32'd3 << 21) | (32'd3 << 16), ld3, NOP, 0);
    // R7 squash priority
    step("R7", mkR(3, 3, 1), ld3, NOP, 1);
    step("R7", mkR(3, 3, 1), ld3, NOP, 0);
    // R8 HALT early in the pipe
    step("R8", hlt, hlt, NOP, 0);
    step("R8", NOP, hlt, NOP, 0);
    // R9 halt arrives and sticks
    step("R9", NOP, NOP, hlt, 0);
    step("R9", mkR(3, 3, 1), ld3, NOP, 0);
    step("R9", NOP, NOP, NOP, 0);
    // R10 squash while halted
    step("R10", mkR(3, 3, 1), ld3, NOP, 1);
    // reset clears the stop
    @(negedge clk);
    rst_n = 1'b0;
    modelHalt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", NOP, NOP, NOP, 0);
    step("R2", mkR(3, 1, 1), ld3, NOP, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule